// File: doc/BRIEF.md
# Palette DAC Host Register Port

This block is the host-side register port of a palette DAC. The host presents a 3-bit register-select code together with a one-cycle read or write strobe and an 8-bit data bus. Eight locations are decoded directly: the two palette address registers, the palette color value, the pixel mask, the pixel command register, the two bytes of a 16-bit index register, and a data window into a small indexed register file. The palette locations are plain storage registers here. The palette RAM, the pixel pipeline and the converters sit outside this block.

Select code 2 is shared. A hidden sequencer counts consecutive reads of that location. At first the location shows the pixel mask. On the fifth consecutive read it shows the pixel command register. If the command register's enable bit is set, the following accesses at code 2 reach the index low byte, then the index high byte, and then the indexed file, which auto-increments the index on every access. After reset the enable bit is clear, so older software that only knows the mask and command registers still sees the simpler device. Any access at another select code puts the sequencer back to its first state.

Top module: `pal_host_port`

## Requirements
- R1: Writing a select code among 0 (palette write address), 1 (palette color), 3 (palette read address) and 6 (pixel command), then reading the same code, returns the written byte. Read data is combinational from the currently mapped register while the read strobe is high.
- R2: After reset the sequencer is in its first state. The pixel command register is 0x00, so bit 4 (the indexed-space enable) is clear. The pixel mask is 0xFF. The index register and the three palette registers are 0.
- R3: In sequencer states 1 to 4, a read at code 2 returns the pixel mask and advances the state by one. The fifth consecutive read at code 2 returns the pixel command register.
- R4: In states 1 to 4, a write at code 2 updates the pixel mask. In state 5 it updates the pixel command register. In all five states it returns the sequencer to state 1.
- R5: A read at code 2 in state 5 moves to state 6 only when command bit 4 is 1. Otherwise the sequencer returns to state 1.
- R6: In state 6, a read or write at code 2 accesses the index low byte and moves to state 7. In state 7 it accesses the index high byte and moves to state 8.
- R7: In state 8, every read or write at code 2 accesses the indexed file entry that the index register points to. The index then increments by one and the sequencer stays in state 8.
- R8: A read or write at any select code other than 2 returns the sequencer to state 1 from any state.
- R9: The index register is 16 bits wide and wraps from 0xFFFF to 0x0000 when it increments.
- R10: The indexed file holds 256 bytes. An index of 256 or above reads as 0x00, and a write at such an index changes no entry.
- R11: Codes 4 and 7 access the index low and high bytes directly. Code 5 accesses the indexed file directly and increments the index. None of these use the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel | input | 3 | Register-select code |
| rd_stb | input | 1 | One-cycle read strobe, taken on the rising edge |
| wr_stb | input | 1 | One-cycle write strobe, taken on the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the register mapped by sel and the sequencer state |

## Verification
The assertions assume that the read and write strobes are never high together, and that each strobe marks exactly one access per clock cycle. Select and write data must be steady during the strobe cycle. The bench drives each access on the falling edge, holds the strobe for exactly one cycle and then leaves one idle cycle. It never raises both strobes at once. It samples read data one time step after the falling edge, inside the strobe cycle, so that it sees the register mapped before the step that the access causes.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Sequencer state for select code 2; the order is behavioural.
  typedef enum logic [2:0] {
    ST_M0   = 3'd0,
    ST_M1   = 3'd1,
    ST_M2   = 3'd2,
    ST_M3   = 3'd3,
    ST_CMD  = 3'd4,
    ST_LO   = 3'd5,
    ST_HI   = 3'd6,
    ST_DATA = 3'd7
  } seq_st_t;

  localparam logic [2:0] SEL_WADDR = 3'd0;
  localparam logic [2:0] SEL_COLOR = 3'd1;
  localparam logic [2:0] SEL_SHARE = 3'd2;
  localparam logic [2:0] SEL_RADDR = 3'd3;
  localparam logic [2:0] SEL_IXLO  = 3'd4;
  localparam logic [2:0] SEL_IXDAT = 3'd5;
  localparam logic [2:0] SEL_CMD   = 3'd6;
  localparam logic [2:0] SEL_IXHI  = 3'd7;

endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    acc_rd,
  input  logic    acc_wr,
  input  logic    at_share,
  input  logic    idx_en,
  output seq_st_t st
);

  seq_st_t st_nxt;
  logic    any_acc;

  assign any_acc = acc_rd | acc_wr;

  always_comb begin
    st_nxt = st;
    if (any_acc) begin
      if (!at_share) begin
        st_nxt = ST_M0;
      end else begin
        unique case (st)
          ST_M0, ST_M1, ST_M2, ST_M3:
            st_nxt = acc_rd ? seq_st_t'(st + 3'd1) : ST_M0;
          ST_CMD:
            st_nxt = (acc_rd && idx_en) ? ST_LO : ST_M0;
          ST_LO:   st_nxt = ST_HI;
          ST_HI:   st_nxt = ST_DATA;
          ST_DATA: st_nxt = ST_DATA;
          default: st_nxt = ST_M0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_M0;
    else if (any_acc) st <= st_nxt;
  end

  a_r3_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && at_share && (st < ST_CMD)) |=> (3'(st) == 3'($past(st) + 3'd1)));

  a_r4_write_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && at_share && (st <= ST_CMD)) |=> (st == ST_M0));

  a_r5_locked_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && at_share && (st == ST_CMD) && !idx_en) |=> (st == ST_M0));

  a_r8_other_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && !at_share) |=> (st == ST_M0));

  a_r7_data_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && at_share && (st == ST_DATA)) |=> (st == ST_DATA));

  a_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd && acc_wr));

endmodule

// File: rtl/pal_index.sv
module pal_index #(
  parameter int DW    = 8,
  parameter int IW    = 16,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic          dat_acc,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic [IW-1:0] idx,
  output logic [DW-1:0] dat_rd
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int HW = IW - DW;

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx_nxt;
  logic          in_range;
  logic [AW-1:0] slot;

  assign in_range = ({1'b0, idx} < (IW+1)'(DEPTH));
  assign slot     = idx[AW-1:0];
  assign dat_rd   = in_range ? mem[slot] : '0;

  always_comb begin
    idx_nxt = idx;
    if (lo_wr)        idx_nxt = {idx[IW-1:DW], wdata};
    else if (hi_wr)   idx_nxt = {wdata[HW-1:0], idx[DW-1:0]};
    else if (dat_acc) idx_nxt = idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (lo_wr || hi_wr || dat_acc) idx <= idx_nxt;
  end

  always_ff @(posedge clk) begin
    if (dat_wr && in_range) mem[slot] <= wdata;
  end

  a_r7_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && !lo_wr && !hi_wr) |=> (idx == $past(idx) + 1'b1));

  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && !lo_wr && !hi_wr && (idx == '1)) |=> (idx == '0));

  a_r11_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_wr || hi_wr || dat_acc) |=> $stable(idx));

  a_r10_wr_implies_acc: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |-> dat_acc);

endmodule

// File: rtl/pal_host_port.sv
module pal_host_port
  import pal_pkg::*;
#(
  parameter int DW     = 8,
  parameter int IW     = 16,
  parameter int DEPTH  = 256,
  parameter int EN_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    sel,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam logic [DW-1:0] MASK_RST = '1;
  localparam logic [DW-1:0] CMD_RST  = '0;

  seq_st_t       st;
  logic          at_share;
  logic          any_acc;
  logic          sh_mask, sh_cmd, sh_lo, sh_hi, sh_dat;
  logic          lo_wr, hi_wr, dat_acc, dat_wr, mask_wr, cmd_wr;
  logic [IW-1:0] idx;
  logic [DW-1:0] dat_rd;
  logic [DW-1:0] waddr_q, raddr_q, color_q, mask_q, cmd_q;

  assign at_share = (sel == SEL_SHARE);
  assign any_acc  = rd_stb | wr_stb;

  assign sh_mask = at_share && (st < ST_CMD);
  assign sh_cmd  = at_share && (st == ST_CMD);
  assign sh_lo   = at_share && (st == ST_LO);
  assign sh_hi   = at_share && (st == ST_HI);
  assign sh_dat  = at_share && (st == ST_DATA);

  assign mask_wr = wr_stb && sh_mask;
  assign cmd_wr  = wr_stb && (sh_cmd || sel == SEL_CMD);
  assign lo_wr   = wr_stb && (sh_lo  || sel == SEL_IXLO);
  assign hi_wr   = wr_stb && (sh_hi  || sel == SEL_IXHI);
  assign dat_acc = any_acc && (sh_dat || sel == SEL_IXDAT);
  assign dat_wr  = wr_stb && dat_acc;

  pal_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_rd   (rd_stb),
    .acc_wr   (wr_stb),
    .at_share (at_share),
    .idx_en   (cmd_q[EN_BIT]),
    .st       (st)
  );

  pal_index #(.DW(DW), .IW(IW), .DEPTH(DEPTH)) u_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_wr   (lo_wr),
    .hi_wr   (hi_wr),
    .dat_acc (dat_acc),
    .dat_wr  (dat_wr),
    .wdata   (wdata),
    .idx     (idx),
    .dat_rd  (dat_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      raddr_q <= '0;
      color_q <= '0;
    end else begin
      if (wr_stb && sel == SEL_WADDR) waddr_q <= wdata;
      if (wr_stb && sel == SEL_RADDR) raddr_q <= wdata;
      if (wr_stb && sel == SEL_COLOR) color_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      cmd_q  <= CMD_RST;
    end else begin
      if (mask_wr) mask_q <= wdata;
      if (cmd_wr)  cmd_q  <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_WADDR: rdata = waddr_q;
      SEL_COLOR: rdata = color_q;
      SEL_RADDR: rdata = raddr_q;
      SEL_IXLO:  rdata = idx[DW-1:0];
      SEL_IXHI:  rdata = DW'(idx[IW-1:DW]);
      SEL_IXDAT: rdata = dat_rd;
      SEL_CMD:   rdata = cmd_q;
      SEL_SHARE: begin
        unique case (st)
          ST_CMD:  rdata = cmd_q;
          ST_LO:   rdata = idx[DW-1:0];
          ST_HI:   rdata = DW'(idx[IW-1:DW]);
          ST_DATA: rdata = dat_rd;
          default: rdata = mask_q;
        endcase
      end
      default: rdata = '0;
    endcase
  end

  a_r4_mask_lands: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wdata)));

  a_r4_cmd_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cmd_q == $past(wdata)));

  a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mask_wr, cmd_wr, lo_wr, hi_wr, dat_wr}) <= 1);

  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(cmd_q));

endmodule

// File: tb/tb_pal_host_port.sv
module tb_pal_host_port;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [2:0] sel;
  logic       rd_stb;
  logic       wr_stb;
  logic [7:0] wdata;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pal_host_port dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [2:0] s, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    sel = s; wdata = d; rd_stb = !w; wr_stb = w;
    #1 q = rdata;
    @(negedge clk);
    rd_stb = 0; wr_stb = 0;
  endtask

  task automatic rdc(input string req, input logic [2:0] s, input logic [7:0] exp);
    logic [7:0] q;
    acc(0, s, 8'h00, q);
    chk(req, q, exp);
  endtask

  task automatic wrc(input logic [2:0] s, input logic [7:0] d);
    logic [7:0] q;
    acc(1, s, d, q);
  endtask

  task automatic rewind();
    logic [7:0] q;
    acc(0, 3'd0, 8'h00, q);
  endtask

  initial begin
    logic [7:0] mask_e, cmd_e;
    sel = 0; rd_stb = 0; wr_stb = 0; wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset state
    rdc("R2 cmd", 3'd6, 8'h00);
    rdc("R2 mask", 3'd2, 8'hFF);
    rdc("R2 waddr", 3'd0, 8'h00);
    rdc("R2 color", 3'd1, 8'h00);
    rdc("R2 raddr", 3'd3, 8'h00);
    rdc("R2 idxlo", 3'd4, 8'h00);
    rdc("R2 idxhi", 3'd7, 8'h00);

    // R1 direct registers
    wrc(3'd0, 8'hA1); wrc(3'd1, 8'hB2); wrc(3'd3, 8'hC3); wrc(3'd6, 8'h2A);
    rdc("R1 waddr", 3'd0, 8'hA1);
    rdc("R1 color", 3'd1, 8'hB2);
    rdc("R1 raddr", 3'd3, 8'hC3);
    rdc("R1 cmd", 3'd6, 8'h2A);
    cmd_e = 8'h2A;
    wrc(3'd2, 8'h5C); mask_e = 8'h5C;
    rdc("R4 mask write", 3'd2, mask_e);

    // R3 / R5 locked sequence
    rewind();
    for (int i = 0; i < 4; i++) rdc("R3 mask read", 3'd2, mask_e);
    rdc("R3 fifth read cmd", 3'd2, cmd_e);
    rdc("R5 locked back to mask", 3'd2, mask_e);

    // R8 interruption sweep
    for (int k = 0; k < 5; k++) begin
      rewind();
      for (int j = 0; j < k; j++) rdc("R3 prefix", 3'd2, mask_e);
      rdc("R8 other code", 3'd0, 8'hA1);
      for (int j = 0; j < 4; j++) rdc("R8 restart mask", 3'd2, mask_e);
      rdc("R8 restart cmd", 3'd2, cmd_e);
    end

    // R4 write at each of states 1..5
    for (int k = 0; k < 5; k++) begin
      rewind();
      for (int j = 0; j < k; j++) rdc("R3 prefix", 3'd2, mask_e);
      if (k < 4) begin wrc(3'd2, 8'(8'h40 + k)); mask_e = 8'(8'h40 + k); end
      else       begin wrc(3'd2, 8'h2B); cmd_e = 8'h2B; end
      for (int j = 0; j < 4; j++) rdc("R4 mask after write", 3'd2, mask_e);
      rdc("R4 cmd after write", 3'd2, cmd_e);
    end

    // R5 enable, R6 index via sequencer, R7 block fill
    wrc(3'd6, 8'h13); cmd_e = 8'h13;
    rewind();
    for (int j = 0; j < 4; j++) rdc("R3 mask", 3'd2, mask_e);
    rdc("R5 cmd", 3'd2, cmd_e);
    wrc(3'd2, 8'h00);
    wrc(3'd2, 8'h00);
    for (int i = 0; i < 256; i++) wrc(3'd2, pat(i));
    rdc("R7 index low after fill", 3'd4, 8'h00);
    rdc("R7 index high after fill", 3'd7, 8'h01);

    // R11 direct readback
    wrc(3'd4, 8'h00); wrc(3'd7, 8'h00);
    for (int i = 0; i < 256; i++) rdc("R11 direct data", 3'd5, pat(i));

    // R6 / R7 sequencer reads
    rewind();
    for (int j = 0; j < 5; j++) begin logic [7:0] q; acc(0, 3'd2, 8'h00, q); end
    wrc(3'd2, 8'h80);
    wrc(3'd2, 8'h00);
    for (int i = 0; i < 4; i++) rdc("R7 seq data", 3'd2, pat(8'h80 + i));
    wrc(3'd4, 8'h12); wrc(3'd7, 8'hAB);
    rewind();
    for (int j = 0; j < 5; j++) begin logic [7:0] q; acc(0, 3'd2, 8'h00, q); end
    rdc("R6 state6 low", 3'd2, 8'h12);
    rdc("R6 state7 high", 3'd2, 8'hAB);
    rdc("R10 out of range seq", 3'd2, 8'h00);
    rdc("R7 index stepped", 3'd4, 8'h13);

    // R10 out of range write ignored
    wrc(3'd4, 8'h34); wrc(3'd7, 8'h12);
    wrc(3'd5, 8'h77);
    wrc(3'd4, 8'h34); wrc(3'd7, 8'h12);
    rdc("R10 read zero", 3'd5, 8'h00);
    wrc(3'd4, 8'h34); wrc(3'd7, 8'h00);
    rdc("R10 no alias", 3'd5, pat(8'h34));

    // R9 wrap
    wrc(3'd4, 8'hFF); wrc(3'd7, 8'hFF);
    rdc("R10 at FFFF", 3'd5, 8'h00);
    rdc("R9 wrap low", 3'd4, 8'h00);
    rdc("R9 wrap high", 3'd7, 8'h00);
    rdc("R9 data at zero", 3'd5, pat(0));
    rdc("R9 step after wrap", 3'd4, 8'h01);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule